// File: doc/BRIEF.md
# Programmable Multiphase Toggle Clock Multiplier

This block builds a multiplied clock from eight phase taps of a locked delay line. The taps are spaced evenly across one reference period, and tap 8 lines up with the reference edge. A 3-bit factor code picks a subset of the taps. The output register changes state once for every rising edge seen on a selected tap. The merged edge train is therefore halved, and the output runs at N/2 times the reference frequency, where N is the number of selected taps (1 to 8).

The taps are sampled by a fast system clock, so the whole block sits in one clock domain. A code change is first registered. It is then handed to the toggle logic only when a rising edge of tap 8 is detected, so a switch never cuts a reference period short. The block also reports the index of the highest selected tap, because that tap is the one fed back to the phase comparator.

Top module: `ecTop`

## Requirements
- R1: While `rstN` is low at a rising `clk` edge, `clkOut` is cleared to 0 at that edge, the factor code register returns to 0 and the tap selection returns to the pattern for code 0.
- R2: A rising edge on a selected tap is detected at the first `clk` edge that samples the tap high after it was sampled low, and `clkOut` inverts at that same edge.
- R3: Rising edges on taps that are not selected never change `clkOut`.
- R4: Code c (0 to 7) selects N = c+1 taps. Tap k of the pattern, for k = 1..N, is tap number ceil(8k/N). Bit i of `phaseIn` is tap number i+1.
- R5: With evenly spaced taps, `clkOut` makes exactly N transitions per reference period, which gives a frequency of N/2 times the reference.
- R6: For N = 1, 2, 4 or 8, `clkOut` is high for exactly half of any window of two reference periods, whatever the high time of the taps.
- R7: A new code takes effect at the first detected rising edge of tap 8 after the code is registered. Until then the previous selection stays in force, and it stays indefinitely if tap 8 never rises.
- R8: `fbTap` gives the 0-based index of the highest selected tap. Every pattern contains tap 8, so the value is 7.
- R9: If several selected taps rise in the same `clk` sample, `clkOut` inverts once for each of them, so it changes only when their count is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the reference |
| rstN | input | 1 | Synchronous active-low reset |
| phaseIn | input | 8 | Delay-line taps; bit i is tap i+1, bit 7 is the reference-aligned tap |
| multCode | input | 3 | Factor code; N = multCode+1 |
| clkOut | output | 1 | Multiplied clock |
| fbTap | output | 3 | Index of the highest selected tap, used for loop feedback |

## Verification
The hardest case to reach is the hand-over window. In that window a new code is registered but not yet applied, and the old pattern must still govern the taps that rise before the next tap 8 edge. The bench changes the code at a known phase offset just after tap 8 has risen. It maps each observed output transition back to the tap whose edge caused it and checks that the old pattern holds until tap 8 rises again. A second stimulus holds tap 8 low, which keeps the old selection in force indefinitely. A third stimulus makes all taps rise together, which exercises the parity rule.

// File: rtl/ecPkg.sv
package ecPkg;
  parameter int unsigned TAPS = 8;
  localparam int unsigned CODE_W = $clog2(TAPS);

  typedef struct packed {
    logic [TAPS-1:0] sel;
  } ecCtl_t;

  // Evenly spread tap pattern: member k of N sits at tap ceil(k*TAPS/N).
  function automatic logic [TAPS-1:0] tapPattern(input logic [CODE_W-1:0] code);
    logic [TAPS-1:0] pat;
    int n;
    int idx;
    pat = '0;
    n = int'(code) + 1;
    for (int k = 1; k <= int'(TAPS); k++) begin
      if (k <= n) begin
        idx = (k * int'(TAPS) + n - 1) / n - 1;
        pat[idx[CODE_W-1:0]] = 1'b1;
      end
    end
    return pat;
  endfunction
endpackage

// File: rtl/ecCtrl.sv
module ecCtrl
  import ecPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] multCode,
  input  logic              lastTapRise,
  output ecCtl_t            ctl,
  output logic [CODE_W-1:0] fbTap
);
  logic [CODE_W-1:0] codeQ;
  logic [TAPS-1:0]   activeMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ      <= '0;
      activeMask <= tapPattern('0);
    end else begin
      codeQ <= multCode;
      if (lastTapRise) activeMask <= tapPattern(codeQ);
    end
  end

  always_comb begin
    fbTap = '0;
    for (int i = 0; i < int'(TAPS); i++) begin
      if (activeMask[i]) fbTap = CODE_W'(i);
    end
  end

  assign ctl.sel = activeMask;
endmodule

// File: rtl/ecDatapath.sv
module ecDatapath
  import ecPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [TAPS-1:0] phaseIn,
  input  ecCtl_t          ctl,
  output logic            clkOut,
  output logic            lastTapRise
);
  logic [TAPS-1:0] phaseQ;
  logic [TAPS-1:0] rise;

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rstN) phaseQ[g] <= 1'b0;
      else       phaseQ[g] <= phaseIn[g];
    end
    assign rise[g] = phaseIn[g] & ~phaseQ[g];
  end

  assign lastTapRise = rise[TAPS-1];

  always_ff @(posedge clk) begin
    if (!rstN) clkOut <= 1'b0;
    else       clkOut <= clkOut ^ (^(rise & ctl.sel));
  end
endmodule

// File: rtl/ecTop.sv
module ecTop
  import ecPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [TAPS-1:0]   phaseIn,
  input  logic [CODE_W-1:0] multCode,
  output logic              clkOut,
  output logic [CODE_W-1:0] fbTap
);
  ecCtl_t          ctl;
  logic            lastTapRise;
  logic [TAPS-1:0] selMask;

  ecCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .multCode(multCode),
    .lastTapRise(lastTapRise), .ctl(ctl), .fbTap(fbTap)
  );

  ecDatapath u_dp (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .ctl(ctl),
    .clkOut(clkOut), .lastTapRise(lastTapRise)
  );

  assign selMask = ctl.sel;
endmodule

// File: rtl/ecChecker.sv
module ecChecker
  import ecPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [TAPS-1:0]   phaseIn,
  input logic [CODE_W-1:0] multCode,
  input logic              clkOut,
  input logic [TAPS-1:0]   selMask
);
  logic [1:0] age;
  logic       rstLowQ = 1'b0;

  always_ff @(posedge clk) begin
    if (!rstN)            age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  always_ff @(posedge clk) begin
    if (rstLowQ) rst_out_low_chk: assert (!clkOut);
    rstLowQ <= !rstN;
  end

  // R2 R3
  toggle_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && clkOut != $past(clkOut)) |->
      (|($past(phaseIn, 1) & ~$past(phaseIn, 2) & $past(selMask, 1))));

  // R7
  sel_update_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && selMask != $past(selMask)) |->
      ($past(phaseIn[TAPS-1], 1) && !$past(phaseIn[TAPS-1], 2)));

  // R4
  sel_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && selMask != $past(selMask)) |->
      ($countones(selMask) == int'($past(multCode, 2)) + 1));

  // R8
  sel_last_tap_chk: assert property (@(posedge clk) disable iff (!rstN)
    selMask[TAPS-1] |=> selMask[TAPS-1]);
endmodule

bind ecTop ecChecker u_chk (
  .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .multCode(multCode),
  .clkOut(clkOut), .selMask(selMask)
);

// File: tb/tb_ecTop.sv
`timescale 1ns/1ps
module tb_ecTop;
  localparam int TAPS = 8;
  localparam int PER  = 2 * TAPS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] phaseIn = '0;
  logic [2:0] multCode = '0;
  logic       clkOut;
  logic [2:0] fbTap;

  int cyc = 0;
  int hiLen = 5;
  int mode = 0;
  bit phEn = 1'b0;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;
  logic curOut, lastOut;
  int cycNow;

  ecTop dut (.clk(clk), .rstN(rstN), .phaseIn(phaseIn), .multCode(multCode),
             .clkOut(clkOut), .fbTap(fbTap));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] wave(int n);
    logic [7:0] w;
    int t, off;
    t = n % PER;
    for (int i = 0; i < TAPS; i++) begin
      off = (mode == 1) ? 0 : (2 * (i + 1)) % PER;
      w[i] = (((t - off + PER) % PER) < hiLen);
      if (mode == 2 && i == 7) w[i] = 1'b0;
    end
    return w;
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    phaseIn <= phEn ? wave(cyc) : 8'h00;
  end

  function automatic logic [7:0] expMask(int n);
    logic [7:0] m;
    m = '0;
    for (int k = 1; k <= n; k++) m[(k * TAPS + n - 1) / n - 1] = 1'b1;
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    lastOut = curOut;
    curOut = clkOut;
    cycNow = cyc;
  endtask

  task automatic alignTo(input int o);
    step();
    while (cycNow % PER != o) step();
  endtask

  task automatic observe(input int nReads, output int trans, output int highs,
                         output logic [7:0] obs, output int odd);
    int t;
    trans = 0; highs = 0; obs = '0; odd = 0;
    for (int r = 0; r < nReads; r++) begin
      step();
      if (curOut) highs++;
      if (curOut != lastOut) begin
        trans++;
        t = (cycNow - 1 + PER) % PER;
        if (t % 2 != 0) odd++;
        else obs[(t == 0) ? 7 : t / 2 - 1] = 1'b1;
      end
    end
  endtask

  initial begin
    int tr, hi, od;
    logic [7:0] ob;
    logic [7:0] em;
    curOut = 1'b0;
    repeat (4) step();
    chk(curOut == 1'b0, "R1 output low in reset", int'(curOut), 0);
    chk(fbTap == 3'd7, "R8 feedback tap after reset", int'(fbTap), 7);
    rstN = 1'b1;
    step();
    phEn = 1'b1;

    // R4 R5 R8 R2 R3: every code, two tap duties
    for (int h = 0; h < 2; h++) begin
      hiLen = (h == 0) ? 3 : 11;
      for (int c = 0; c < 8; c++) begin
        multCode = 3'(c);
        repeat (3 * PER) step();
        alignTo(0);
        observe(PER, tr, hi, ob, od);
        em = expMask(c + 1);
        chk(tr == c + 1, "R5 transitions per period", tr, c + 1);
        chk(ob == em && od == 0, "R4 R2 R3 toggling taps", int'(ob), int'(em));
        chk(fbTap == 3'd7, "R8 feedback tap", int'(fbTap), 7);
        if (c == 0 || c == 1 || c == 3 || c == 7) begin
          alignTo(0);
          observe(2 * PER, tr, hi, ob, od);
          chk(hi == PER, "R6 duty over two periods", hi, PER);
        end
      end
    end

    // R7: change just after tap 8 edge; old pattern until next tap 8 edge
    hiLen = 5;
    multCode = 3'd1;
    repeat (3 * PER) step();
    alignTo(2);
    multCode = 3'd7;
    observe(PER - 3, tr, hi, ob, od);
    em = expMask(2) & 8'h7f;
    chk(ob == em && od == 0, "R7 old pattern held", int'(ob), int'(em));
    observe(1, tr, hi, ob, od);
    observe(PER, tr, hi, ob, od);
    chk(ob == 8'hff, "R7 new pattern after tap 8 edge", int'(ob), 255);
    chk(tr == 8, "R7 new factor transitions", tr, 8);

    // R3 R7: tap 8 silent, only unselected taps pulse
    multCode = 3'd0;
    repeat (3 * PER) step();
    mode = 2;
    step(); step();
    multCode = 3'd7;
    repeat (2) step();
    observe(3 * PER, tr, hi, ob, od);
    chk(tr == 0, "R3 R7 no toggles without tap 8", tr, 0);
    mode = 0;
    repeat (3 * PER) step();
    alignTo(0);
    observe(PER, tr, hi, ob, od);
    chk(tr == 8, "R7 pending code applied on tap 8 return", tr, 8);

    // R9: coincident edges
    mode = 1;
    hiLen = 8;
    for (int c = 0; c < 4; c++) begin
      multCode = 3'(c);
      repeat (3 * PER) step();
      alignTo(0);
      observe(PER, tr, hi, ob, od);
      chk(tr == ((c + 1) % 2), "R9 parity of coincident edges", tr, (c + 1) % 2);
    end

    // R1: mid-run reset
    mode = 0;
    hiLen = 5;
    multCode = 3'd0;
    repeat (3 * PER) step();
    for (int i = 0; i < 3 * PER && curOut != 1'b1; i++) step();
    chk(curOut == 1'b1, "R1 output high before reset", int'(curOut), 1);
    rstN = 1'b0;
    phEn = 1'b0;
    step();
    chk(curOut == 1'b0, "R1 reset clears output", int'(curOut), 0);
    repeat (3) step();
    chk(fbTap == 3'd7, "R1 R8 selection after reset", int'(fbTap), 7);
    rstN = 1'b1;
    step();
    chk(curOut == 1'b0, "R1 output low after release", int'(curOut), 0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule